// File: doc/BRIEF.md
# SD card clock prescaler divider

This block turns a requested card-clock rate into a two-stage divider setting for an SD host: a power-of-two prescaler feeding a linear divisor of 1 to 16. A start strobe latches the base-clock rate and the target rate. The block shuts the card clock off, searches the prescaler and then the divisor over several cycles, and loads the encoded fields. It reopens the clock only once those fields hold the new setting.

The achieved rate, base divided by prescaler times divisor, is computed by a bit-serial division and reported beside the fields. A vendor revision input raises the smallest prescaler for older silicon. The divided card clock is a registered square wave. Its half-period is prescaler × divisor cycles of `clk`, so `clk` is taken to run at twice the base rate. It stays low whenever the enable is off.

Top module: `sd_clk_prescaler`

## Requirements
- R1: The prescaler search starts at 1 when `vendor_rev` is 0x13 or above, and at 2 when `vendor_rev` is below 0x13.
- R2: The prescaler doubles while floor(base / prescaler / 16) exceeds the target and the prescaler is below 256.
- R3: With the prescaler fixed, the divisor rises from 1 while floor(base / prescaler / divisor) exceeds the target and the divisor is below 16.
- R4: `pre_code` holds the prescaler shifted right by one (prescaler 1 gives 0, 256 gives 128), and `div_code` holds the divisor minus one.
- R5: On the clock edge that accepts `start`, `clk_en`, `card_clk`, `pre_code`, `div_code` and `freq_out` all drop to zero.
- R6: A target of zero ends at once with `done` high, `clk_en` low, `freq_out` zero and both codes zero.
- R7: `freq_out` equals floor(base / (prescaler × divisor)), so the lowest reachable rate is base / 4096.
- R8: For a nonzero target, `done` is a single-cycle pulse, and `clk_en` and the new codes become valid in that same cycle.
- R9: `card_clk` is low while `clk_en` is low. It first rises N `clk` cycles after `clk_en` rises and then toggles every N cycles, where N = prescaler × divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, twice the base rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a new setting; accepted only when idle |
| base_hz | input | 32 | Base clock frequency |
| target_hz | input | 32 | Requested card-clock frequency |
| vendor_rev | input | 8 | Controller vendor revision |
| card_clk | output | 1 | Divided, enable-gated card clock |
| clk_en | output | 1 | Card clock enable |
| pre_code | output | 8 | Encoded prescaler |
| div_code | output | 4 | Encoded divisor |
| freq_out | output | 32 | Achieved frequency |
| done | output | 1 | One-cycle pulse when a setting is in place |

## Verification
The bench drives targets right at exact divisor boundaries. A design that compares with greater-or-equal instead of greater-than would then pick one divisor step too many. It also drives tiny targets against large bases. These runs push both caps, and a design missing a cap would run past 256 or 16, or wrap its codes. Vendor revisions 0x12 and 0x13 sit on either side of the threshold, so an off-by-one in that rule shows up as a prescaler code of 0 instead of 1. Measured card-clock edges after the enable returns catch a counter that was not reloaded, which would show up as a short first phase.

// File: rtl/sd_clk_prescaler.sv
module sd_clk_prescaler #(
  parameter int FW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] base_hz,
  input  logic [FW-1:0] target_hz,
  input  logic [7:0]    vendor_rev,
  output logic          card_clk,
  output logic          clk_en,
  output logic [7:0]    pre_code,
  output logic [3:0]    div_code,
  output logic [FW-1:0] freq_out,
  output logic          done
);
  localparam int CW = $clog2(FW);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_DIV, S_QUO, S_LOAD} st_t;
  st_t st;

  logic [FW-1:0] base_q, tgt_q, dvd, quo;
  logic [3:0]    psh;
  logic [4:0]    dv;
  logic [5:0]    rem;
  logic [CW-1:0] bitn;
  logic [12:0]   cnt;

  wire [FW-1:0]   pre_q   = base_q >> psh;
  wire [FW-1:0]   pre16_q = base_q >> ({1'b0, psh} + 5'd4);
  wire [FW+8:0]   lim     = ({9'd0, tgt_q} + 1'b1) * {{FW+4{1'b0}}, dv};
  wire            div_up  = {9'd0, pre_q} >= lim;
  wire [5:0]      rem_sh  = {rem[4:0], dvd[FW-1]};
  wire            ge      = rem_sh >= {1'b0, dv};
  wire [12:0]     ratio   = 13'(dv) << psh;
  wire            accept  = start && st == S_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; base_q <= '0; tgt_q <= '0; dvd <= '0; quo <= '0;
      psh <= '0; dv <= 5'd1; rem <= '0; bitn <= '0;
      clk_en <= 1'b0; pre_code <= '0; div_code <= '0; freq_out <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          clk_en <= 1'b0; pre_code <= '0; div_code <= '0; freq_out <= '0;
          base_q <= base_hz; tgt_q <= target_hz;
          psh <= (vendor_rev < 8'h13) ? 4'd1 : 4'd0;
          if (target_hz == '0) done <= 1'b1;
          else st <= S_PRE;
        end
        S_PRE:
          if (psh < 4'd8 && pre16_q > tgt_q) psh <= psh + 4'd1;
          else begin dv <= 5'd1; st <= S_DIV; end
        S_DIV:
          if (dv < 5'd16 && div_up) dv <= dv + 5'd1;
          else begin dvd <= pre_q; rem <= '0; quo <= '0; bitn <= '0; st <= S_QUO; end
        S_QUO: begin
          rem  <= ge ? rem_sh - {1'b0, dv} : rem_sh;
          quo  <= {quo[FW-2:0], ge};
          dvd  <= dvd << 1;
          bitn <= bitn + 1'b1;
          if (bitn == CW'(FW - 1)) st <= S_LOAD;
        end
        S_LOAD: begin
          pre_code <= 8'((9'd1 << psh) >> 1);
          div_code <= 4'(dv - 5'd1);
          freq_out <= quo;
          clk_en   <= 1'b1;
          done     <= 1'b1;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; card_clk <= 1'b0;
    end else if (!clk_en || accept) begin
      cnt <= '0; card_clk <= 1'b0;
    end else if (cnt == ratio - 13'd1) begin
      cnt <= '0; card_clk <= ~card_clk;
    end else begin
      cnt <= cnt + 13'd1;
    end
  end

  // R5
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!clk_en && !card_clk && pre_code == '0 && freq_out == '0));
  // R9
  gated_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> !card_clk);
  // R9
  no_runt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> !card_clk);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  zero_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clk_en) |-> (freq_out == '0 && div_code == '0));
  // R4
  pre_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pre_code));
endmodule

// File: tb/sd_clk_prescaler_tb.sv
module sd_clk_prescaler_tb;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] base_hz = '0, target_hz = '0;
  logic [7:0] vendor_rev = 8'h13;
  logic card_clk, clk_en, done;
  logic [7:0] pre_code;
  logic [3:0] div_code;
  logic [31:0] freq_out;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sd_clk_prescaler u_dut (.clk(clk), .rst_n(rst_n), .start(start), .base_hz(base_hz),
    .target_hz(target_hz), .vendor_rev(vendor_rev), .card_clk(card_clk), .clk_en(clk_en),
    .pre_code(pre_code), .div_code(div_code), .freq_out(freq_out), .done(done));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model(input longint b, input longint t, input int v,
                                output int pre, output int dv, output longint f);
    pre = (v < 'h13) ? 2 : 1;
    while (b / pre / 16 > t && pre < 256) pre *= 2;
    dv = 1;
    while (b / pre / dv > t && dv < 16) dv++;
    f = b / pre / dv;
  endfunction

  task automatic run(input longint b, input longint t, input int v, input bit meas);
    int pre, dv, k;
    longint f;
    @(negedge clk);
    base_hz = 32'(b); target_hz = 32'(t); vendor_rev = 8'(v); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (t == 0) begin
      chk(done && !clk_en && freq_out == 0 && pre_code == 0 && div_code == 0,
          "R6", {32'd0, freq_out}, 0);
      return;
    end
    chk(!clk_en && !card_clk && pre_code == 0 && div_code == 0 && freq_out == 0,
        "R5", {31'd0, clk_en}, 0);
    k = 0;
    while (!done && k < 200) begin @(negedge clk); k++; end
    model(b, t, v, pre, dv, f);
    chk(done && clk_en, "R8", {31'd0, clk_en}, 1);
    chk(pre_code == 8'(pre >> 1), "R1 R2 R4 prescaler", pre_code, pre >> 1);
    chk(div_code == 4'(dv - 1), "R3 R4 divisor", div_code, dv - 1);
    chk(freq_out == 32'(f), "R7", freq_out, f);
    if (meas) begin
      k = 0;
      while (!card_clk && k < 5000) begin @(negedge clk); k++; end
      chk(k == pre * dv, "R9 first rise", k, pre * dv);
      k = 0;
      while (card_clk && k < 5000) begin @(negedge clk); k++; end
      chk(k == pre * dv, "R9 half period", k, pre * dv);
    end else begin
      @(negedge clk);
      chk(!done, "R8 pulse", {31'd0, done}, 0);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !finished) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd7);
    repeat (3) @(negedge clk);
    chk(!clk_en && !card_clk && !done && freq_out == 0, "R5 reset", {31'd0, clk_en}, 0);
    rst_n = 1'b1;
    run(1000, 100, 'h13, 1);
    run(1000, 100, 'h12, 1);
    run(1000, 99, 'h13, 1);
    run(3200, 200, 'h13, 1);
    run(64'hFFFF_FFFF, 1, 'h13, 0);
    run(64'hFFFF_FFFF, 64'hFFFF_FFFF, 'h12, 0);
    run(64'hFFFF_FFFF, 64'hFFFF_FFFF, 'h13, 0);
    run(5000, 0, 'h13, 0);
    run(48000, 1000, 'h10, 0);
    run(48000, 1000, 'h20, 0);
    for (int i = 0; i < 80; i++) begin
      longint b, t;
      int v;
      b = {32'd0, $urandom};
      case ($urandom % 3)
        0: t = {32'd0, $urandom} % (b / 16 + 1);
        1: t = b >> ($urandom % 14);
        default: t = {32'd0, $urandom} >> ($urandom % 32);
      endcase
      v = ($urandom % 2) ? 'h12 : 'h13;
      run(b, t, v, 0);
    end
    for (int i = 0; i < 6; i++) begin
      run(64'd100 + {32'd0, $urandom % 400}, 1 + {32'd0, $urandom % 40}, 'h13, 1);
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule